// File: doc/BRIEF.md
# Control Endpoint Transfer-Size Register

This block is the software-visible transfer-size register of a USB device control endpoint. Software loads a byte count (7 bits) and a packet count (2 bits) before a transfer. Hardware then counts both values down as packets move through the endpoint FIFO. The `dir_in` input sets the direction. For an IN transfer (device to host), a packet written into the transmit FIFO from memory lowers the byte count by that packet's length. A packet read out of the transmit FIFO toward the bus lowers the packet count by one. For an OUT transfer (host to device) the roles swap: a packet written into the receive FIFO lowers the packet count, and a packet drained from the receive FIFO to memory lowers the byte count.

A one-cycle `xfer_done` pulse is raised when hardware consumes the last programmed byte. Software that programs the byte count equal to the maximum packet size therefore gets one pulse per packet. Access goes through a single address/write-enable/write-data port. Read data reflects the live counters whenever the address matches the register offset.

A small state machine tracks the byte counter. It has three states:
- **IDLE**: byte count is zero.
- **RUN**: byte count is nonzero.
- **DONE**: the single pulse cycle.

Its transitions are:
- **LOAD_GO** (any state to RUN): software writes a nonzero size.
- **LOAD_STOP** (any state to IDLE): software writes zero.
- **DRAIN** (RUN to DONE): a hardware decrement reaches zero.
- **RETIRE** (DONE to IDLE): the cycle after DRAIN, when no write occurs.
- **HOLD**: every other case keeps the current state.

Top module: `ep_xfer_size_reg`

## Requirements
- R1: After reset the byte count and packet count are zero, and `xfer_done` is low.
- R2: When `addr` equals 0x910, `rd_data` returns the byte count in bits 6:0 and the packet count in bits 20:19, with all other bits zero. At any other address `rd_data` is zero.
- R3: A write takes effect only when `wr_en` is high and `addr` equals 0x910. It loads bits 6:0 into the byte count and bits 20:19 into the packet count, and writes to other bits are ignored.
- R4: With `dir_in`=1, a `fifo_wr_valid` event lowers the byte count by `fifo_wr_len`, and a `fifo_rd_valid` event lowers the packet count by one.
- R5: With `dir_in`=0, a `fifo_wr_valid` event lowers the packet count by one, and a `fifo_rd_valid` event lowers the byte count by `fifo_rd_len`.
- R6: Both counters saturate at zero and never wrap.
- R7: A register write in the same cycle as a hardware decrement wins: the counters take the written values.
- R8: When a hardware decrement takes a nonzero byte count to zero, `xfer_done` is high for exactly one cycle: the first cycle in which the byte count reads zero.
- R9: `xfer_done` stays low after a software write (including a write of zero), and after decrements of an already-zero byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Register address for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data (live counters) |
| dir_in | input | 1 | 1 = IN transfer, 0 = OUT transfer |
| fifo_wr_valid | input | 1 | A packet was written into the endpoint FIFO |
| fifo_wr_len | input | 7 | Byte length of the written packet |
| fifo_rd_valid | input | 1 | A packet was read out of the endpoint FIFO |
| fifo_rd_len | input | 7 | Byte length of the read packet |
| xfer_done | output | 1 | One-cycle pulse when the byte count is exhausted |

## Verification
Several functions can fall in the same cycle, and the bench provokes each overlap deliberately:
- A software load and a hardware decrement (the priority case).
- A decrement that reaches zero and a simultaneous load (no pulse may appear).
- Push and pop events together, which hit both counters in one cycle.

Directed cases place a write on the same edge as a draining event. Seeded random stimulus then mixes writes, both events and both directions freely. After every edge, a bench model built from the requirements predicts the read data and the pulse, and both are compared at the ports.

// File: rtl/ep_xfer_pkg.sv
package ep_xfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } xfer_state_t;
endpackage

// File: rtl/ep_down_counter.sv
module ep_down_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    input  logic [W-1:0] dec_amt,
    output logic [W-1:0] cnt,
    output logic         hits_zero
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec)
            cnt <= (cnt > dec_amt) ? cnt - dec_amt : '0;
    end

    assign hits_zero = !load && dec && (cnt != '0) && (cnt <= dec_amt);

    // R6: an oversized decrement lands on zero, never wraps
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && dec && cnt < dec_amt) |=> cnt == '0);
    // R7: load has priority over a decrement
    a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));
endmodule

// File: rtl/ep_xfer_fsm.sv
module ep_xfer_fsm
    import ep_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_nonzero,
    input  logic hits_zero,
    output logic done
);
    xfer_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        if (load) begin
            state_nx = load_nonzero ? ST_RUN : ST_IDLE;      // LOAD_GO / LOAD_STOP
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;                   // HOLD
                ST_RUN:  state_nx = hits_zero ? ST_DONE : ST_RUN; // DRAIN / HOLD
                ST_DONE: state_nx = ST_IDLE;                   // RETIRE
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        done = (state == ST_DONE);
    end

    // R8: the pulse lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: a drain to zero produces the pulse
    a_r8_drain_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        hits_zero |=> done);
    // R9: a software write never produces the pulse
    a_r9_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !done);
endmodule

// File: rtl/ep_xfer_size_reg.sv
module ep_xfer_size_reg #(
    parameter int          ADDR_W     = 12,
    parameter int          DATA_W     = 32,
    parameter int          SIZE_W     = 7,
    parameter int          PKT_W      = 2,
    parameter int          SIZE_LSB   = 0,
    parameter int          PKT_LSB    = 19,
    parameter logic [11:0] REG_OFFSET = 12'h910
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              dir_in,
    input  logic              fifo_wr_valid,
    input  logic [SIZE_W-1:0] fifo_wr_len,
    input  logic              fifo_rd_valid,
    input  logic [SIZE_W-1:0] fifo_rd_len,
    output logic              xfer_done
);
    localparam logic [DATA_W-1:0] FIELD_MASK =
        ({{(DATA_W-SIZE_W){1'b0}}, {SIZE_W{1'b1}}} << SIZE_LSB) |
        ({{(DATA_W-PKT_W){1'b0}},  {PKT_W{1'b1}}}  << PKT_LSB);
    localparam logic [PKT_W-1:0] PKT_ONE = {{(PKT_W-1){1'b0}}, 1'b1};

    logic              sel, wr_hit;
    logic [SIZE_W-1:0] byte_cnt, byte_amt;
    logic [PKT_W-1:0]  pkt_cnt;
    logic              byte_dec, pkt_dec, byte_zero_hit;
    logic              unused_pkt_zero;
    logic              unused_wr_bits;

    assign sel    = (addr == REG_OFFSET[ADDR_W-1:0]);
    assign wr_hit = wr_en && sel;

    // Direction steers each FIFO-side event to one counter
    assign byte_dec = dir_in ? fifo_wr_valid : fifo_rd_valid;
    assign byte_amt = dir_in ? fifo_wr_len   : fifo_rd_len;
    assign pkt_dec  = dir_in ? fifo_rd_valid : fifo_wr_valid;

    assign unused_wr_bits = ^(wr_data & ~FIELD_MASK);

    ep_down_counter #(.W(SIZE_W)) u_bytes (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_hit),
        .load_val  (wr_data[SIZE_LSB +: SIZE_W]),
        .dec       (byte_dec),
        .dec_amt   (byte_amt),
        .cnt       (byte_cnt),
        .hits_zero (byte_zero_hit)
    );

    ep_down_counter #(.W(PKT_W)) u_pkts (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_hit),
        .load_val  (wr_data[PKT_LSB +: PKT_W]),
        .dec       (pkt_dec),
        .dec_amt   (PKT_ONE),
        .cnt       (pkt_cnt),
        .hits_zero (unused_pkt_zero)
    );

    ep_xfer_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (wr_hit),
        .load_nonzero (wr_data[SIZE_LSB +: SIZE_W] != '0),
        .hits_zero    (byte_zero_hit),
        .done         (xfer_done)
    );

    always_comb begin
        rd_data = '0;
        if (sel) begin
            rd_data[SIZE_LSB +: SIZE_W] = byte_cnt;
            rd_data[PKT_LSB +: PKT_W]   = pkt_cnt;
        end
    end

    // R2: reserved positions always read zero
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~FIELD_MASK) == '0);
    // R4: IN push lowers the byte count by the packet length
    a_r4_in_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_in && fifo_wr_valid && !wr_hit && byte_cnt > fifo_wr_len)
        |=> byte_cnt == $past(byte_cnt) - $past(fifo_wr_len));
    // R5: OUT push lowers the packet count by one
    a_r5_out_pkt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_in && fifo_wr_valid && !wr_hit && pkt_cnt != '0)
        |=> pkt_cnt == $past(pkt_cnt) - PKT_ONE);
    // R8: the pulse only appears with the byte count at zero
    a_r8_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> byte_cnt == '0);
endmodule

// File: tb/ep_xfer_size_reg_test.sv
`timescale 1ns/1ps
module ep_xfer_size_reg_test;
    localparam logic [11:0] OFF = 12'h910;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = OFF;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        dir_in = 1'b1;
    logic        fifo_wr_valid = 1'b0;
    logic [6:0]  fifo_wr_len = '0;
    logic        fifo_rd_valid = 1'b0;
    logic [6:0]  fifo_rd_len = '0;
    logic        xfer_done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [6:0] m_size = '0;
    logic [1:0] m_pkt  = '0;
    logic       m_done = 1'b0;

    always #5 clk = ~clk;

    ep_xfer_size_reg uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .dir_in(dir_in), .fifo_wr_valid(fifo_wr_valid),
        .fifo_wr_len(fifo_wr_len), .fifo_rd_valid(fifo_rd_valid),
        .fifo_rd_len(fifo_rd_len), .xfer_done(xfer_done)
    );

    function automatic logic [31:0] exp_read(logic [11:0] a, logic [6:0] s, logic [1:0] p);
        logic [31:0] v = '0;
        if (a == OFF) begin
            v[6:0]   = s;
            v[20:19] = p;
        end
        return v;
    endfunction

    function automatic logic [6:0] sat_sub(logic [6:0] a, logic [6:0] b);
        return (a > b) ? a - b : 7'd0;
    endfunction

    task automatic model_edge();
        logic hit  = wr_en && (addr == OFF);
        logic bdec = dir_in ? fifo_wr_valid : fifo_rd_valid;
        logic [6:0] bamt = dir_in ? fifo_wr_len : fifo_rd_len;
        logic pdec = dir_in ? fifo_rd_valid : fifo_wr_valid;
        m_done = 1'b0;
        if (hit) begin
            m_size = wr_data[6:0];
            m_pkt  = wr_data[20:19];
        end else begin
            if (bdec) begin
                if (m_size != 0 && m_size <= bamt) m_done = 1'b1;
                m_size = sat_sub(m_size, bamt);
            end
            if (pdec) m_pkt = (m_pkt != 0) ? m_pkt - 2'd1 : 2'd0;
        end
    endtask

    task automatic check(string tag);
        logic [31:0] er = exp_read(addr, m_size, m_pkt);
        n_tests++;
        if (rd_data !== er) begin
            n_fail++;
            $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, er);
        end
        n_tests++;
        if (xfer_done !== m_done) begin
            n_fail++;
            $display("FAIL %s xfer_done actual=%b expected=%b", tag, xfer_done, m_done);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; fifo_wr_valid = 1'b0; fifo_rd_valid = 1'b0;
        addr = OFF;
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag);
        idle_inputs();
    endtask

    task automatic do_write(logic [31:0] d, string tag);
        wr_en = 1'b1; wr_data = d; step(tag);
    endtask

    task automatic push(logic [6:0] len, string tag);
        fifo_wr_valid = 1'b1; fifo_wr_len = len; step(tag);
    endtask

    task automatic pop(logic [6:0] len, string tag);
        fifo_rd_valid = 1'b1; fifo_rd_len = len; step(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state");

        // R3 / R2: all-ones write keeps only the two fields
        do_write(32'hFFFF_FFFF, "R3 all-ones write R2 layout");
        addr = 12'h914; @(negedge clk); check("R2 other address reads zero");
        // R3: wrong address write ignored
        addr = 12'h90C; wr_en = 1'b1; wr_data = 32'h0000_0005; step("R3 miss write ignored");

        // R4: IN direction
        dir_in = 1'b1;
        do_write({11'd0, 2'd2, 12'd0, 7'd100}, "R3 load 100/2");
        push(7'd64, "R4 IN push lowers bytes");
        pop(7'd64, "R4 IN pop lowers packets");
        push(7'd36, "R8 IN drain to zero");
        step("R8 pulse gone");
        pop(7'd5, "R6 packet count floor");
        pop(7'd5, "R6 packet count saturates");
        push(7'd20, "R9 no pulse on zero bytes");

        // R5: OUT direction
        dir_in = 1'b0;
        do_write({11'd0, 2'd3, 12'd0, 7'd50}, "R3 load 50/3");
        push(7'd99, "R5 OUT push lowers packets only");
        pop(7'd30, "R5 OUT pop lowers bytes");
        pop(7'd90, "R6 R8 oversize drain saturates");

        // R7: write beats same-cycle decrement
        do_write({11'd0, 2'd1, 12'd0, 7'd10}, "R3 load 10/1");
        wr_en = 1'b1; wr_data = {11'd0, 2'd2, 12'd0, 7'd40};
        fifo_rd_valid = 1'b1; fifo_rd_len = 7'd10;
        fifo_wr_valid = 1'b1; fifo_wr_len = 7'd1;
        step("R7 write wins over drain");
        // R9: write of zero while running gives no pulse
        do_write(32'd0, "R9 write zero quiet");
        step("R9 still quiet");

        // Seeded random mix
        for (int i = 0; i < 3000; i++) begin
            dir_in        = $urandom_range(0, 1);
            wr_en         = ($urandom_range(0, 9) == 0);
            wr_data       = $urandom;
            addr          = ($urandom_range(0, 7) == 0) ? 12'($urandom) : OFF;
            fifo_wr_valid = ($urandom_range(0, 2) == 0);
            fifo_wr_len   = 7'($urandom_range(0, 40));
            fifo_rd_valid = ($urandom_range(0, 2) == 0);
            fifo_rd_len   = 7'($urandom_range(0, 40));
            step("R2 R3 R4 R5 R6 R7 R8 R9 random");
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule